// File: doc/BRIEF.md
# Lightweight Authenticated-Encryption Bus Wrapper

This block attaches an authenticated-encryption core to a 32-bit APB bus with the least storage possible: a key register, a nonce register, one block-wide input word and one block-wide result word. There is no buffering. Software writes one block as WORDS consecutive bus writes to a single data port. The last of those writes hands the block to the core. Software then reads the same number of result words from a single result port before it may send the next block.

The wrapper runs a four-phase cycle: fill, send, wait, drain. In the send phase it holds the block on the core interface until the core signals that it is ready, which covers the start-up and finalization periods when the core cannot accept data. It latches the core's result, paces the result reads with a read counter and reports through a status word when a block result or the tag is available. Writes that would break the write-block/read-block alternation are discarded and raise a sticky error flag.

Word map (word index = byte address / 4): 0 control (write), 1 status (read), 2 data-in port, 3 result port, 4..7 key, 8..11 nonce, 12..15 tag. Bus word j of any wide value occupies bits [32j+31:32j]; the first data word written is bits [31:0] of the block.

Top module: `aead_lite_wrap`

## Requirements
- R1: After reset the status word reads 0x1 (bit0 accepting input, all other bits 0), and no core pulse or block valid is asserted.
- R2: Writes to the data-in port in the fill phase store bus word k at block bits [32k+31:32k] in write order; from the cycle after the WORDS-th write, core_word_valid_o stays high with a constant core_word_o until a cycle in which core_ready_i is high.
- R3: When core_result_valid_i arrives after the block was taken, status bit1 (result ready) sets and bit0 clears; WORDS reads of the result port return result words 0 to WORDS-1 in order, after which bit1 clears and bit0 sets again.
- R4: A data-in write outside the fill phase changes neither the pending block nor the pending result and sets status bit3 (sequence error), which stays set until a control write with bit2 set.
- R5: A control write with bit0 set gives a one-cycle core_init_o, clears status bit2 and returns the wrapper to an empty fill phase, discarding partly written words; bit0 takes precedence over bit1 in the same write.
- R6: A control write with bit1 set gives a one-cycle core_fin_o only in the fill phase with no word of the current block written; otherwise no pulse is produced and status bit3 sets.
- R7: core_tag_valid_i latches core_tag_i and sets status bit2; tag register j (word 12+j) returns tag bits [32j+31:32j] once bit2 is set and 0 while it is clear.
- R8: Key word j and nonce word j written at word 4+j and 8+j appear on core_key_o and core_nonce_o at bits [32j+31:32j] from the next cycle.
- R9: A read of the result port while no result is pending returns 0 and does not advance the read sequence.
- R10: pready_o is high in every cycle; every access completes without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| core_key_o | output | 128 | Key to the core |
| core_nonce_o | output | 128 | Nonce to the core |
| core_init_o | output | 1 | One-cycle start of core initialization |
| core_fin_o | output | 1 | One-cycle start of core finalization |
| core_word_valid_o | output | 1 | Block offered to the core |
| core_word_o | output | 32*WORDS | Block data |
| core_ready_i | input | 1 | Core accepts the offered block this cycle |
| core_result_valid_i | input | 1 | Result block valid |
| core_result_i | input | 32*WORDS | Result block |
| core_tag_valid_i | input | 1 | Tag valid pulse |
| core_tag_i | input | 128 | Tag value |

## Verification
The bench builds the wrapper with four bus words per block and an 8-bit address. The counters therefore wrap at three, which makes the last-word handoff and the last-read rearm show up after a short sequence. A behavioural model of the phases, with its own copies of the block, result, key and tag, is compared on every clock against the core-side outputs and against every bus read. A stub core in the bench holds ready low after initialization and finalization and can be stalled on demand. This brings within reach a block held through several unready cycles, writes dropped during send and drain, finalization requested in the middle of a block, and initialization that discards a partly written block.

// File: rtl/aead_lite_pkg.sv
package aead_lite_pkg;
  typedef enum logic [1:0] {PH_FILL, PH_SEND, PH_WAIT, PH_DRAIN} phase_e;

  // control word bits
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_FIN   = 1;
  localparam int unsigned CTRL_CLR   = 2;

  // word offsets inside the base group
  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_STAT = 2'd1;
  localparam logic [1:0] SUB_DIN  = 2'd2;
  localparam logic [1:0] SUB_DOUT = 2'd3;

  // groups of four words
  localparam logic [1:0] GRP_BASE  = 2'd0;
  localparam logic [1:0] GRP_KEY   = 2'd1;
  localparam logic [1:0] GRP_NONCE = 2'd2;
  localparam logic [1:0] GRP_TAG   = 2'd3;
endpackage

// File: rtl/aead_lite_seq.sv
module aead_lite_seq
  import aead_lite_pkg::*;
#(
  parameter int unsigned WORDS = 4,
  localparam int unsigned CNT_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_wr_i,
  input  logic             dout_rd_i,
  input  logic             start_i,
  input  logic             fin_req_i,
  input  logic             clr_err_i,
  input  logic             core_ready_i,
  input  logic             res_valid_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] wcnt_o,
  output logic [CNT_W-1:0] rcnt_o,
  output logic             res_load_o,
  output logic             init_o,
  output logic             fin_o,
  output logic             seq_err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] wcnt_q, rcnt_q;
  logic             init_q, fin_q, err_q;
  logic             fin_ok, bad_wr, bad_fin;

  assign fin_ok     = (phase_q == PH_FILL) && (wcnt_q == '0);
  assign bad_wr     = din_wr_i && (phase_q != PH_FILL);
  assign bad_fin    = fin_req_i && !start_i && !fin_ok;
  assign res_load_o = (phase_q == PH_WAIT) && res_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILL;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (start_i) begin
      phase_q <= PH_FILL;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_FILL: if (din_wr_i) begin
          if (wcnt_q == LAST) begin
            wcnt_q  <= '0;
            phase_q <= PH_SEND;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        PH_SEND: if (core_ready_i) phase_q <= PH_WAIT;
        PH_WAIT: if (res_valid_i) phase_q <= PH_DRAIN;
        PH_DRAIN: if (dout_rd_i) begin
          if (rcnt_q == LAST) begin
            rcnt_q  <= '0;
            phase_q <= PH_FILL;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_FILL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      fin_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      init_q <= start_i;
      fin_q  <= fin_req_i && !start_i && fin_ok;
      if (clr_err_i) err_q <= 1'b0;
      else if (bad_wr || bad_fin) err_q <= 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign wcnt_o    = wcnt_q;
  assign rcnt_o    = rcnt_q;
  assign init_o    = init_q;
  assign fin_o     = fin_q;
  assign seq_err_o = err_q;
endmodule

// File: rtl/aead_lite_wordbuf.sv
module aead_lite_wordbuf #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned CNT_W = $clog2(WORDS),
  localparam int unsigned BLK_W = 32 * WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             load_i,
  input  logic [BLK_W-1:0] load_data_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [BLK_W-1:0] in_word_o,
  output logic [31:0]      rd_word_o
);
  logic [31:0] in_q  [WORDS];
  logic [31:0] out_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[g]  <= '0;
        out_q[g] <= '0;
      end else begin
        if (wr_en_i && (wr_idx_i == CNT_W'(g))) in_q[g] <= wr_data_i;
        if (load_i) out_q[g] <= load_data_i[32*g +: 32];
      end
    end
    assign in_word_o[32*g +: 32] = in_q[g];
  end

  assign rd_word_o = out_q[rd_idx_i];
endmodule

// File: rtl/aead_lite_keystore.sv
module aead_lite_keystore (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         key_wr_i,
  input  logic         nonce_wr_i,
  input  logic [1:0]   sel_i,
  input  logic [31:0]  wdata_i,
  input  logic         start_i,
  input  logic         tag_valid_i,
  input  logic [127:0] tag_i,
  output logic [127:0] key_o,
  output logic [127:0] nonce_o,
  output logic [31:0]  tag_word_o,
  output logic         tag_done_o
);
  logic [31:0] key_q [4];
  logic [31:0] non_q [4];
  logic [31:0] tag_q [4];
  logic        done_q;

  for (genvar j = 0; j < 4; j++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q[j] <= '0;
        non_q[j] <= '0;
        tag_q[j] <= '0;
      end else begin
        if (key_wr_i && sel_i == 2'(j))   key_q[j] <= wdata_i;
        if (nonce_wr_i && sel_i == 2'(j)) non_q[j] <= wdata_i;
        if (tag_valid_i)                  tag_q[j] <= tag_i[32*j +: 32];
      end
    end
    assign key_o[32*j +: 32]   = key_q[j];
    assign nonce_o[32*j +: 32] = non_q[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          done_q <= 1'b0;
    else if (start_i)     done_q <= 1'b0;
    else if (tag_valid_i) done_q <= 1'b1;
  end

  assign tag_done_o = done_q;
  assign tag_word_o = done_q ? tag_q[sel_i] : 32'h0;
endmodule

// File: rtl/aead_lite_wrap.sv
module aead_lite_wrap
  import aead_lite_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned BLK_W = 32 * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic [127:0]      core_key_o,
  output logic [127:0]      core_nonce_o,
  output logic              core_init_o,
  output logic              core_fin_o,
  output logic              core_word_valid_o,
  output logic [BLK_W-1:0]  core_word_o,
  input  logic              core_ready_i,
  input  logic              core_result_valid_i,
  input  logic [BLK_W-1:0]  core_result_i,
  input  logic              core_tag_valid_i,
  input  logic [127:0]      core_tag_i
);
  localparam int unsigned CNT_W = $clog2(WORDS);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic [1:0]       grp, sub;
  logic             in_map, acc_wr, acc_rd;
  logic             start, fin_req, clr_err, din_wr, dout_rd, tag_rd;
  logic             key_wr, nonce_wr, ctrl_wr;
  logic             unused_addr_lsb;

  phase_e           phase;
  logic [CNT_W-1:0] wcnt, rcnt;
  logic             res_load, seq_err, tag_done;
  logic [31:0]      res_word, tag_word;

  assign widx            = paddr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^paddr_i[1:0];
  assign in_map          = (widx[IDX_W-1:4] == '0);
  assign grp             = widx[3:2];
  assign sub             = widx[1:0];
  assign acc_wr          = psel_i && penable_i && pwrite_i && in_map;
  assign acc_rd          = psel_i && penable_i && !pwrite_i && in_map;

  assign ctrl_wr  = acc_wr && grp == GRP_BASE && sub == SUB_CTRL;
  assign start    = ctrl_wr && pwdata_i[CTRL_START];
  assign fin_req  = ctrl_wr && pwdata_i[CTRL_FIN];
  assign clr_err  = ctrl_wr && pwdata_i[CTRL_CLR];
  assign din_wr   = acc_wr && grp == GRP_BASE && sub == SUB_DIN;
  assign dout_rd  = acc_rd && grp == GRP_BASE && sub == SUB_DOUT;
  assign key_wr   = acc_wr && grp == GRP_KEY;
  assign nonce_wr = acc_wr && grp == GRP_NONCE;
  assign tag_rd   = acc_rd && grp == GRP_TAG;

  aead_lite_seq #(.WORDS(WORDS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .din_wr_i     (din_wr),
    .dout_rd_i    (dout_rd),
    .start_i      (start),
    .fin_req_i    (fin_req),
    .clr_err_i    (clr_err),
    .core_ready_i (core_ready_i),
    .res_valid_i  (core_result_valid_i),
    .phase_o      (phase),
    .wcnt_o       (wcnt),
    .rcnt_o       (rcnt),
    .res_load_o   (res_load),
    .init_o       (core_init_o),
    .fin_o        (core_fin_o),
    .seq_err_o    (seq_err)
  );

  aead_lite_wordbuf #(.WORDS(WORDS)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (din_wr && phase == PH_FILL),
    .wr_idx_i    (wcnt),
    .wr_data_i   (pwdata_i),
    .load_i      (res_load),
    .load_data_i (core_result_i),
    .rd_idx_i    (rcnt),
    .in_word_o   (core_word_o),
    .rd_word_o   (res_word)
  );

  aead_lite_keystore u_keys (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (key_wr),
    .nonce_wr_i  (nonce_wr),
    .sel_i       (sub),
    .wdata_i     (pwdata_i),
    .start_i     (start),
    .tag_valid_i (core_tag_valid_i),
    .tag_i       (core_tag_i),
    .key_o       (core_key_o),
    .nonce_o     (core_nonce_o),
    .tag_word_o  (tag_word),
    .tag_done_o  (tag_done)
  );

  assign core_word_valid_o = (phase == PH_SEND);
  assign pready_o          = 1'b1;

  always_comb begin
    prdata_o = 32'h0;
    if (in_map) begin
      unique case (grp)
        GRP_BASE: begin
          if (sub == SUB_STAT)
            prdata_o = {28'h0, seq_err, tag_done, phase == PH_DRAIN, phase == PH_FILL};
          else if (sub == SUB_DOUT && phase == PH_DRAIN)
            prdata_o = res_word;
        end
        GRP_TAG: prdata_o = tag_word;
        default: prdata_o = 32'h0;
      endcase
    end
  end
endmodule

module aead_lite_wrap_chk #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned BLK_W = 32 * WORDS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_word_valid_o,
  input logic [BLK_W-1:0] core_word_o,
  input logic             core_ready_i,
  input logic             core_init_o,
  input logic             core_fin_o,
  input logic             start,
  input logic             clr_err,
  input logic             din_wr,
  input logic             tag_rd,
  input logic             tag_done,
  input logic             seq_err,
  input logic             is_fill,
  input logic             is_drain,
  input logic [31:0]      prdata_o
);
  AST_BLOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_word_valid_o && !core_ready_i && !start |=> core_word_valid_o && $stable(core_word_o)); // R2
  AST_NO_OFFER_IN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_drain |-> !core_word_valid_o); // R3
  AST_DROP_FLAGS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_wr && !is_fill |=> seq_err); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err && !clr_err |=> seq_err); // R4
  AST_INIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_init_o |=> !core_init_o); // R5
  AST_FIN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_fin_o |=> !core_fin_o); // R6
  AST_TAG_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_rd && !tag_done |-> prdata_o == 32'h0); // R7
endmodule

bind aead_lite_wrap aead_lite_wrap_chk #(.WORDS(WORDS)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .core_word_valid_o (core_word_valid_o),
  .core_word_o       (core_word_o),
  .core_ready_i      (core_ready_i),
  .core_init_o       (core_init_o),
  .core_fin_o        (core_fin_o),
  .start             (start),
  .clr_err           (clr_err),
  .din_wr            (din_wr),
  .tag_rd            (tag_rd),
  .tag_done          (tag_done),
  .seq_err           (seq_err),
  .is_fill           (phase == aead_lite_pkg::PH_FILL),
  .is_drain          (phase == aead_lite_pkg::PH_DRAIN),
  .prdata_o          (prdata_o)
);

// File: tb/aead_lite_wrap_test.sv
module aead_lite_wrap_test;
  localparam int WORDS = 4;
  localparam int BLK_W = 32 * WORDS;
  localparam logic [127:0] TAGV = 128'hC0DE_0003_C0DE_0002_C0DE_0001_C0DE_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             psel = 0, penable = 0, pwrite = 0;
  logic [7:0]       paddr = 0;
  logic [31:0]      pwdata = 0;
  logic [31:0]      prdata;
  logic             pready;
  logic [127:0]     core_key, core_nonce;
  logic             core_init, core_fin, core_valid;
  logic [BLK_W-1:0] core_word;
  logic             core_ready;
  logic             rv = 0, tv = 0;
  logic [BLK_W-1:0] rres = '0;

  aead_lite_wrap #(.WORDS(WORDS), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .core_key_o(core_key), .core_nonce_o(core_nonce), .core_init_o(core_init),
    .core_fin_o(core_fin), .core_word_valid_o(core_valid), .core_word_o(core_word),
    .core_ready_i(core_ready), .core_result_valid_i(rv), .core_result_i(rres),
    .core_tag_valid_i(tv), .core_tag_i(TAGV)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input logic [255:0] got, input logic [255:0] exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int n, input int i);
    return 32'h6C00_0000 ^ 32'(n << 8) ^ 32'(i);
  endfunction

  // stub core
  int busy = 0, blk_no = 0;
  logic stall = 0, tpend = 0;
  assign core_ready = (busy == 0) && !stall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; blk_no <= 0; tpend <= 0; rv <= 0; tv <= 0;
    end else begin
      rv <= 0; tv <= 0;
      if (core_init) busy <= 5;
      else if (core_fin) begin busy <= 6; tpend <= 1; end
      else if (busy > 0) busy <= busy - 1;
      if (busy == 1 && tpend) begin tv <= 1; tpend <= 0; end
      if (core_valid && core_ready) begin
        rv <= 1;
        for (int i = 0; i < WORDS; i++) rres[32*i +: 32] <= core_word[32*i +: 32] ^ mk(blk_no, i);
        blk_no <= blk_no + 1;
      end
    end
  end

  // behavioural reference of the wrapper (0 fill, 1 send, 2 wait, 3 drain)
  int m_phase, m_wcnt, m_rcnt;
  logic [31:0] m_in [WORDS];
  logic [31:0] m_out [WORDS];
  logic [31:0] m_key [4];
  logic [31:0] m_non [4];
  logic [31:0] m_tag [4];
  logic m_err, m_tagd, m_init, m_fin;

  always @(posedge clk or negedge rst_n) begin
    logic wr, rd, st, fr, cl;
    int a;
    if (!rst_n) begin
      m_phase = 0; m_wcnt = 0; m_rcnt = 0; m_err = 0; m_tagd = 0; m_init = 0; m_fin = 0;
      for (int i = 0; i < WORDS; i++) begin m_in[i] = 0; m_out[i] = 0; end
      for (int i = 0; i < 4; i++) begin m_key[i] = 0; m_non[i] = 0; m_tag[i] = 0; end
    end else begin
      wr = psel && penable && pwrite;
      rd = psel && penable && !pwrite;
      a  = int'(paddr >> 2);
      st = wr && a == 0 && pwdata[0];
      fr = wr && a == 0 && pwdata[1];
      cl = wr && a == 0 && pwdata[2];
      m_init = st;
      m_fin  = fr && !st && m_phase == 0 && m_wcnt == 0;
      if (cl) m_err = 0;
      else if ((wr && a == 2 && m_phase != 0) || (fr && !st && !(m_phase == 0 && m_wcnt == 0))) m_err = 1;
      if (wr && a >= 4 && a < 8) m_key[a-4] = pwdata;
      if (wr && a >= 8 && a < 12) m_non[a-8] = pwdata;
      if (st) m_tagd = 0;
      else if (tv) begin
        m_tagd = 1;
        for (int i = 0; i < 4; i++) m_tag[i] = TAGV[32*i +: 32];
      end
      if (st) begin
        m_phase = 0; m_wcnt = 0; m_rcnt = 0;
      end else if (m_phase == 0) begin
        if (wr && a == 2) begin
          m_in[m_wcnt] = pwdata;
          m_wcnt++;
          if (m_wcnt == WORDS) begin m_wcnt = 0; m_phase = 1; end
        end
      end else if (m_phase == 1) begin
        if (core_ready) m_phase = 2;
      end else if (m_phase == 2) begin
        if (rv) begin
          for (int i = 0; i < WORDS; i++) m_out[i] = rres[32*i +: 32];
          m_phase = 3;
        end
      end else if (rd && a == 3) begin
        m_rcnt++;
        if (m_rcnt == WORDS) begin m_rcnt = 0; m_phase = 0; end
      end
    end
  end

  function automatic logic [31:0] m_rdata(input logic [7:0] ad);
    int a = int'(ad >> 2);
    if (a == 1) return {28'h0, m_err, m_tagd, m_phase == 3, m_phase == 0};
    if (a == 3) return (m_phase == 3) ? m_out[m_rcnt] : 32'h0;
    if (a >= 12 && a < 16) return m_tagd ? m_tag[a-12] : 32'h0;
    return 32'h0;
  endfunction

  // per-clock comparison of the core side
  always @(negedge clk) begin
    logic [BLK_W-1:0] ew;
    logic [127:0] ek, en;
    if (rst_n) begin
      for (int i = 0; i < WORDS; i++) ew[32*i +: 32] = m_in[i];
      for (int i = 0; i < 4; i++) begin ek[32*i +: 32] = m_key[i]; en[32*i +: 32] = m_non[i]; end
      chk(256'(core_valid), 256'(m_phase == 1), "R2 valid");
      if (core_valid) chk(256'(core_word), 256'(ew), "R2 word");
      chk(256'(core_init), 256'(m_init), "R5 init pulse");
      chk(256'(core_fin), 256'(m_fin), "R6 fin pulse");
      chk(256'(core_key), 256'(ek), "R8 key");
      chk(256'(core_nonce), 256'(en), "R8 nonce");
      chk(256'(pready), 256'(1'b1), "R10 pready");
    end
  end

  task automatic apb_write(input logic [7:0] ad, input logic [31:0] d);
    @(posedge clk); #2;
    psel = 1; pwrite = 1; paddr = ad; pwdata = d; penable = 0;
    @(posedge clk); #2;
    penable = 1;
    @(posedge clk); #2;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] ad, input string req, output logic [31:0] d);
    @(posedge clk); #2;
    psel = 1; pwrite = 0; paddr = ad; penable = 0;
    @(posedge clk); #2;
    penable = 1;
    @(negedge clk);
    d = prdata;
    chk(256'(d), 256'(m_rdata(ad)), req);
    @(posedge clk); #2;
    psel = 0; penable = 0;
  endtask

  task automatic wait_bit(input int b, input string req);
    logic [31:0] s;
    for (int k = 0; k < 60; k++) begin
      apb_read(8'h04, req, s);
      if (s[b]) return;
    end
    chk(256'(0), 256'(1), {req, " status bit timeout"});
  endtask

  task automatic send_block(input logic [31:0] w [WORDS]);
    for (int i = 0; i < WORDS; i++) apb_write(8'h08, w[i]);
  endtask

  task automatic drain(input logic [31:0] w [WORDS], input int n);
    logic [31:0] d;
    for (int i = 0; i < WORDS; i++) begin
      apb_read(8'h0C, "R3 result read", d);
      chk(256'(d), 256'(w[i] ^ mk(n, i)), "R3 result word");
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] blk [WORDS];
    int nb;
    nb = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(256'({core_init, core_fin, core_valid}), 256'(0), "R1 no core activity");
    apb_read(8'h04, "R1 status", d);
    chk(256'(d), 256'(32'h1), "R1 status reset");
    apb_read(8'h0C, "R9 idle result", d);
    chk(256'(d), 256'(0), "R9 idle result zero");
    apb_read(8'h30, "R7 tag before done", d);
    chk(256'(d), 256'(0), "R7 tag hidden");

    for (int j = 0; j < 4; j++) apb_write(8'(8'h10 + 4*j), 32'h1111_0000 + j);
    for (int j = 0; j < 4; j++) apb_write(8'(8'h20 + 4*j), 32'h2222_0000 + j);
    @(negedge clk);
    chk(256'(core_key[63:32]), 256'(32'h1111_0001), "R8 key word1");
    chk(256'(core_nonce[127:96]), 256'(32'h2222_0003), "R8 nonce word3");

    // block A right after init: core busy, block held
    apb_write(8'h00, 32'h1);
    for (int i = 0; i < WORDS; i++) blk[i] = 32'hA000_0000 + i;
    send_block(blk);
    apb_read(8'h04, "R2 status after block", d);
    chk(256'(d[0]), 256'(0), "R2 not accepting after block");
    wait_bit(1, "R3 ready");
    apb_write(8'h08, 32'hDEAD_BEEF);
    apb_read(8'h04, "R4 status", d);
    chk(256'(d[3]), 256'(1), "R4 drop in drain sets err");
    drain(blk, nb); nb++;
    apb_read(8'h04, "R3 status rearm", d);
    chk(256'(d[1:0]), 256'(2'b01), "R3 rearmed");
    apb_read(8'h0C, "R9 extra read", d);
    chk(256'(d), 256'(0), "R9 extra read zero");
    apb_write(8'h00, 32'h4);
    apb_read(8'h04, "R4 clear", d);
    chk(256'(d[3]), 256'(0), "R4 err cleared");

    // block B with stalled core, write during send
    stall = 1;
    for (int i = 0; i < WORDS; i++) blk[i] = 32'hB000_0010 + i;
    send_block(blk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(256'(core_valid), 256'(1), "R2 held while stalled");
    apb_write(8'h08, 32'h0BAD_0BAD);
    @(posedge clk); #2 stall = 0;
    wait_bit(1, "R3 ready B");
    drain(blk, nb); nb++;
    apb_write(8'h00, 32'h4);

    // finalize mid-block is refused
    apb_write(8'h08, 32'hC000_0000);
    apb_write(8'h08, 32'hC000_0001);
    apb_write(8'h00, 32'h2);
    apb_read(8'h04, "R6 status", d);
    chk(256'(d[3]), 256'(1), "R6 mid-block fin sets err");
    blk[0] = 32'hC000_0000; blk[1] = 32'hC000_0001;
    blk[2] = 32'hC000_0002; blk[3] = 32'hC000_0003;
    apb_write(8'h08, blk[2]);
    apb_write(8'h08, blk[3]);
    wait_bit(1, "R3 ready C");
    drain(blk, nb); nb++;

    // finalize and tag
    apb_write(8'h00, 32'h2);
    wait_bit(2, "R7 tag wait");
    for (int j = 0; j < 4; j++) begin
      apb_read(8'(8'h30 + 4*j), "R7 tag read", d);
      chk(256'(d), 256'(TAGV[32*j +: 32]), "R7 tag word");
    end

    // restart clears tag and discards a partial block
    apb_write(8'h00, 32'h1);
    apb_read(8'h04, "R5 status", d);
    chk(256'(d[2]), 256'(0), "R5 tag done cleared");
    apb_read(8'h3C, "R7 tag after restart", d);
    chk(256'(d), 256'(0), "R7 tag hidden again");
    apb_write(8'h08, 32'hEEEE_0000);
    apb_write(8'h08, 32'hEEEE_0001);
    apb_write(8'h00, 32'h3);
    for (int i = 0; i < WORDS; i++) blk[i] = 32'hD000_0020 + i;
    send_block(blk);
    wait_bit(1, "R5 ready D");
    drain(blk, nb); nb++;

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule